// File: doc/BRIEF.md
# Odd/Even Pixel Link Splitter

This block sits between a parallel pixel source and the output link encoders of a display path. It receives one RGB pixel per pixel-clock cycle, together with horizontal sync, vertical sync and data-enable. It presents the stream on two output links, called the odd link and the even link. In single-link operation the stream goes through to the odd link at full rate, and the even link stays idle. In dual-link operation consecutive active pixels are paired. The first pixel of a pair lands on the odd link and the second on the even link. Both links then update together once every two input cycles. In replicate operation every pixel is copied onto both links at full rate.

Pairing is re-anchored at each rising edge of data-enable, so the first pixel of every active run is always an odd pixel, whatever happened in blanking. A run that ends on an odd pixel is closed with an even slot that carries data-enable low. Both links advance on a shared clock-enable, `link_ce`, which the downstream encoders use as their half-rate (dual) or full-rate (single, replicate) timing. A format input selects 24-bit or 18-bit colour. The mode is only taken up while data-enable is low, so an active line never mixes layouts.

Top module: `pix_dual_splitter`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), every link output, `link_ce` and `mode_act` are zero.
- R2: Mode encoding: 2'b00 is single, 2'b01 is dual, 2'b10 is replicate, and 2'b11 is treated as single. In single mode the odd link shows the input pixel, syncs and data-enable one cycle after the input edge. The even link shows all zeros, and `link_ce` is high every cycle.
- R3: In dual mode the pixel of an odd slot is held, and on the following even slot the odd link shows the held pixel while the even link shows the current pixel. Both links load on the same edge and `link_ce` pulses for one cycle right after the even slot.
- R4: A data-enable rising edge forces that cycle to be an odd slot, so no link load follows it, even when the free-running pair phase would have made it an even slot.
- R5: Each link carries the hsync, vsync and data-enable sampled in the same cycle as its own pixel, so control bits stay aligned with the data on both links.
- R6: If an active run ends after an odd pixel, the next cycle is an even slot. In it, the odd link shows the last pixel with data-enable high, and the even link keeps its previous pixel with data-enable low.
- R7: In replicate mode both links show identical pixel and control values one cycle after input, and `link_ce` is high every cycle.
- R8: `mode_req` is adopted only on an edge where `de_in` is low. The new mode governs from the next cycle on, and `mode_act` reports the mode in force.
- R9: When `fmt_18` is high, the lowest `DROP_BITS` (default 2) bits of each `COLOR_W`-bit colour field are forced to zero on the link data. When it is low, all bits pass.
- R10: In dual mode `link_ce` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested link mode (00 single, 01 dual, 10 replicate, 11 single) |
| fmt_18 | input | 1 | High selects reduced 18-bit colour depth |
| pix_in | input | PIX_W (24) | Input RGB pixel |
| hs_in | input | 1 | Input horizontal sync |
| vs_in | input | 1 | Input vertical sync |
| de_in | input | 1 | Input data-enable |
| link_ce | output | 1 | Link advance strobe: both links loaded on the previous edge |
| mode_act | output | 2 | Mode currently in force |
| odd_pix | output | PIX_W (24) | Odd link pixel |
| odd_hs | output | 1 | Odd link horizontal sync |
| odd_vs | output | 1 | Odd link vertical sync |
| odd_de | output | 1 | Odd link data-enable |
| even_pix | output | PIX_W (24) | Even link pixel |
| even_hs | output | 1 | Even link horizontal sync |
| even_vs | output | 1 | Even link vertical sync |
| even_de | output | 1 | Even link data-enable |

## Verification
The bench drives data-enable rises while the free pair phase points at an even slot. A design without re-anchoring would then load the links early and pair a blank pixel with the first active one. It ends an active run on an odd pixel. A wrong design would drop the last pixel or raise even data-enable on stale data. It requests mode changes in mid-line, which must be ignored until blanking, or the line layout would tear. It also sends hsync and vsync pulses on single pixels of a pair, which expose a control path that lags or leads its pixel by a slot.

// File: rtl/psp_pkg.sv
package psp_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_REPL   = 2'b10,
    MODE_RSVD   = 2'b11
  } link_mode_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;

  // Reserved code falls back to single-link operation.
  function automatic link_mode_e decode_mode(input logic [1:0] code);
    link_mode_e m;
    m = link_mode_e'(code);
    if (m == MODE_RSVD) m = MODE_SINGLE;
    return m;
  endfunction

  // Next pair phase: an odd slot leaves the pair half full (1), an even slot closes it (0).
  function automatic logic next_phase(input logic slot_is_odd);
    return slot_is_odd;
  endfunction

  // A slot is odd when data-enable just rose, or when no pair is open.
  function automatic logic odd_slot(input logic rise, input logic phase_open);
    return rise | ~phase_open;
  endfunction

endpackage

// File: rtl/psp_fmt_mask.sv
module psp_fmt_mask #(
  parameter int COLOR_W   = 8,
  parameter int N_COLORS  = 3,
  parameter int DROP_BITS = 2,
  localparam int PIX_W    = COLOR_W * N_COLORS
) (
  input  logic             fmt_18,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] pix_o
);

  localparam int KEEP_W = COLOR_W - DROP_BITS;

  for (genvar c = 0; c < N_COLORS; c++) begin : g_color
    assign pix_o[c*COLOR_W + DROP_BITS +: KEEP_W] = pix_i[c*COLOR_W + DROP_BITS +: KEEP_W];
    assign pix_o[c*COLOR_W +: DROP_BITS] = fmt_18 ? '0 : pix_i[c*COLOR_W +: DROP_BITS];
  end

endmodule

// File: rtl/psp_mode_ctrl.sv
module psp_mode_ctrl
  import psp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       de_in,
  output link_mode_e mode_q,
  output logic       mode_take
);

  // Mode requests are taken up only in blanking.
  assign mode_take = ~de_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SINGLE;
    end else if (mode_take) begin
      mode_q <= decode_mode(mode_req);
    end
  end

endmodule

// File: rtl/psp_pair_phase.sv
module psp_pair_phase
  import psp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dual_en,
  input  logic de_in,
  output logic de_rise,
  output logic slot_odd,
  output logic slot_even
);

  logic de_prev;
  logic pair_open;

  assign de_rise   = de_in & ~de_prev;
  assign slot_odd  = odd_slot(de_rise, pair_open);
  assign slot_even = ~slot_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_prev   <= 1'b0;
      pair_open <= 1'b0;
    end else begin
      de_prev   <= de_in;
      pair_open <= dual_en ? next_phase(slot_odd) : 1'b0;
    end
  end

endmodule

// File: rtl/psp_link_reg.sv
module psp_link_reg
  import psp_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ld_pix,
  input  logic [PIX_W-1:0] pix_d,
  input  sync_t            ctl_d,
  output logic [PIX_W-1:0] pix_q,
  output sync_t            ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      ctl_q <= '0;
    end else if (ld) begin
      ctl_q <= ctl_d;
      if (ld_pix) pix_q <= pix_d;
    end
  end

endmodule

// File: rtl/pix_dual_splitter.sv
module pix_dual_splitter
  import psp_pkg::*;
#(
  parameter int COLOR_W   = 8,
  parameter int N_COLORS  = 3,
  parameter int DROP_BITS = 2,
  localparam int PIX_W    = COLOR_W * N_COLORS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_req,
  input  logic             fmt_18,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             de_in,
  output logic             link_ce,
  output logic [1:0]       mode_act,
  output logic [PIX_W-1:0] odd_pix,
  output logic             odd_hs,
  output logic             odd_vs,
  output logic             odd_de,
  output logic [PIX_W-1:0] even_pix,
  output logic             even_hs,
  output logic             even_vs,
  output logic             even_de
);

  localparam int N_LINKS = 2;
  localparam int L_ODD   = 0;
  localparam int L_EVEN  = 1;

  // Named internal events, observed by the checker.
  link_mode_e       mode_q;
  logic             mode_take;
  logic             de_rise;
  logic             slot_odd;
  logic             slot_even;
  logic             dual_en;
  logic             pair_done;

  logic [PIX_W-1:0] cur_pix;
  sync_t            cur_ctl;
  logic [PIX_W-1:0] hold_pix;
  sync_t            hold_ctl;

  logic             ld     [N_LINKS];
  logic             ld_pix [N_LINKS];
  logic [PIX_W-1:0] pix_d  [N_LINKS];
  sync_t            ctl_d  [N_LINKS];
  logic [PIX_W-1:0] pix_q  [N_LINKS];
  sync_t            ctl_q  [N_LINKS];
  logic             ce_d;

  assign cur_ctl = '{hs: hs_in, vs: vs_in, de: de_in};

  psp_fmt_mask #(
    .COLOR_W  (COLOR_W),
    .N_COLORS (N_COLORS),
    .DROP_BITS(DROP_BITS)
  ) u_mask (
    .fmt_18(fmt_18),
    .pix_i (pix_in),
    .pix_o (cur_pix)
  );

  psp_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .de_in    (de_in),
    .mode_q   (mode_q),
    .mode_take(mode_take)
  );

  assign dual_en = (mode_q == MODE_DUAL);

  psp_pair_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual_en  (dual_en),
    .de_in    (de_in),
    .de_rise  (de_rise),
    .slot_odd (slot_odd),
    .slot_even(slot_even)
  );

  assign pair_done = dual_en & slot_even;

  // Odd-slot holding register for the first pixel of a pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_pix <= '0;
      hold_ctl <= '0;
    end else if (dual_en && slot_odd) begin
      hold_pix <= cur_pix;
      hold_ctl <= cur_ctl;
    end
  end

  // Per-link load selection.
  always_comb begin
    ce_d = 1'b1;
    for (int l = 0; l < N_LINKS; l++) begin
      ld[l]     = 1'b1;
      ld_pix[l] = 1'b1;
      pix_d[l]  = cur_pix;
      ctl_d[l]  = cur_ctl;
    end
    unique case (mode_q)
      MODE_DUAL: begin
        ce_d          = pair_done;
        ld[L_ODD]     = pair_done;
        pix_d[L_ODD]  = hold_pix;
        ctl_d[L_ODD]  = hold_ctl;
        ld[L_EVEN]    = pair_done;
        // Even pixel data only moves on an active even slot (flush keeps it).
        ld_pix[L_EVEN] = de_in;
      end
      MODE_REPL: begin
        ce_d = 1'b1;
      end
      default: begin
        pix_d[L_EVEN] = '0;
        ctl_d[L_EVEN] = '0;
      end
    endcase
  end

  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    psp_link_reg #(.PIX_W(PIX_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld[g]),
      .ld_pix(ld_pix[g]),
      .pix_d (pix_d[g]),
      .ctl_d (ctl_d[g]),
      .pix_q (pix_q[g]),
      .ctl_q (ctl_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_ce <= 1'b0;
    else        link_ce <= ce_d;
  end

  assign mode_act = mode_q;
  assign odd_pix  = pix_q[L_ODD];
  assign odd_hs   = ctl_q[L_ODD].hs;
  assign odd_vs   = ctl_q[L_ODD].vs;
  assign odd_de   = ctl_q[L_ODD].de;
  assign even_pix = pix_q[L_EVEN];
  assign even_hs  = ctl_q[L_EVEN].hs;
  assign even_vs  = ctl_q[L_EVEN].vs;
  assign even_de  = ctl_q[L_EVEN].de;

endmodule

// File: rtl/psp_checker.sv
module psp_checker #(
  parameter int COLOR_W   = 8,
  parameter int N_COLORS  = 3,
  parameter int DROP_BITS = 2,
  localparam int PIX_W    = COLOR_W * N_COLORS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fmt_18,
  input logic             de_in,
  input logic             de_rise,
  input logic             link_ce,
  input logic [1:0]       mode_act,
  input logic [PIX_W-1:0] odd_pix,
  input logic             odd_hs,
  input logic             odd_de,
  input logic [PIX_W-1:0] even_pix,
  input logic             even_hs,
  input logic             even_de
);

  localparam logic [1:0] M_SINGLE = 2'b00;
  localparam logic [1:0] M_DUAL   = 2'b01;
  localparam logic [1:0] M_REPL   = 2'b10;

  logic [PIX_W-1:0] low_mask;
  always_comb begin
    low_mask = '0;
    for (int c = 0; c < N_COLORS; c++) begin
      for (int b = 0; b < DROP_BITS; b++) low_mask[c*COLOR_W + b] = 1'b1;
    end
  end

  // R2: single mode advances every cycle and leaves the even link idle.
  a_r2_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == M_SINGLE) |=> link_ce);
  a_r2_single_even_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == M_SINGLE) |=> (!even_de && !even_hs && even_pix == '0));

  // R4: a data-enable rise opens a pair, so no link load follows it.
  a_r4_rise_is_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == M_DUAL && de_rise) |=> !link_ce);

  // R6: an even slot never carries data without its odd partner.
  a_r6_even_needs_odd: assert property (@(posedge clk) disable iff (!rst_n)
    even_de |-> odd_de);

  // R7: replicate drives identical links.
  a_r7_repl_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == M_REPL) |=> (odd_pix == even_pix && odd_de == even_de && odd_hs == even_hs));

  // R8: the mode is frozen while data-enable is high.
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    de_in |=> $stable(mode_act));

  // R9: reduced colour depth clears the low bits of each field.
  a_r9_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_18 && mode_act != M_DUAL) |=> ((odd_pix & low_mask) == '0));

  // R10: dual mode never advances the links on back-to-back cycles.
  a_r10_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == M_DUAL && link_ce) |=> !link_ce);

endmodule

bind pix_dual_splitter psp_checker #(
  .COLOR_W  (COLOR_W),
  .N_COLORS (N_COLORS),
  .DROP_BITS(DROP_BITS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fmt_18  (fmt_18),
  .de_in   (de_in),
  .de_rise (de_rise),
  .link_ce (link_ce),
  .mode_act(mode_act),
  .odd_pix (odd_pix),
  .odd_hs  (odd_hs),
  .odd_de  (odd_de),
  .even_pix(even_pix),
  .even_hs (even_hs),
  .even_de (even_de)
);

// File: tb/pix_dual_splitter_tb.sv
`timescale 1ns/1ps
module pix_dual_splitter_tb;

  localparam int PIX_W = 24;
  localparam int N_ROWS = 27;
  localparam int WATCHDOG_CYCLES = 200000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode_req;
  logic             fmt_18;
  logic [PIX_W-1:0] pix_in;
  logic             hs_in, vs_in, de_in;
  logic             link_ce;
  logic [1:0]       mode_act;
  logic [PIX_W-1:0] odd_pix, even_pix;
  logic             odd_hs, odd_vs, odd_de, even_hs, even_vs, even_de;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pix_dual_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .fmt_18(fmt_18),
    .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .link_ce(link_ce), .mode_act(mode_act),
    .odd_pix(odd_pix), .odd_hs(odd_hs), .odd_vs(odd_vs), .odd_de(odd_de),
    .even_pix(even_pix), .even_hs(even_hs), .even_vs(even_vs), .even_de(even_de)
  );

  // Row: mode de hs pix | ce odd_de odd_hs odd_pix even_de even_hs even_pix
  // Expected values are the outputs just after the edge that samples the row.
  // Column ce covers R10 cadence, columns hs cover R5 alignment.
  localparam logic [32:0] TBL [N_ROWS] = '{
    {2'd0,1'b1,1'b0,8'hA1, 1'b1,1'b1,1'b0,8'hA1, 1'b0,1'b0,8'h00},
    {2'd0,1'b1,1'b1,8'hA2, 1'b1,1'b1,1'b1,8'hA2, 1'b0,1'b0,8'h00},
    {2'd0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00},
    {2'd1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00},
    {2'd1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00},
    {2'd1,1'b1,1'b1,8'hB1, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00},
    {2'd1,1'b1,1'b1,8'hB2, 1'b1,1'b1,1'b1,8'hB1, 1'b1,1'b1,8'hB2},
    {2'd1,1'b1,1'b0,8'hB3, 1'b0,1'b1,1'b1,8'hB1, 1'b1,1'b1,8'hB2},
    {2'd1,1'b1,1'b0,8'hB4, 1'b1,1'b1,1'b0,8'hB3, 1'b1,1'b0,8'hB4},
    {2'd1,1'b1,1'b0,8'hB5, 1'b0,1'b1,1'b0,8'hB3, 1'b1,1'b0,8'hB4},
    {2'd1,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'hB5, 1'b0,1'b0,8'hB4},
    {2'd1,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'hB5, 1'b0,1'b0,8'hB4},
    {2'd1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,8'hB4},
    {2'd1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'hB4},
    {2'd1,1'b1,1'b0,8'hC1, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'hB4},
    {2'd1,1'b1,1'b0,8'hC2, 1'b1,1'b1,1'b0,8'hC1, 1'b1,1'b0,8'hC2},
    {2'd1,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'hC1, 1'b1,1'b0,8'hC2},
    {2'd1,1'b1,1'b0,8'hD1, 1'b0,1'b1,1'b0,8'hC1, 1'b1,1'b0,8'hC2},
    {2'd1,1'b1,1'b0,8'hD2, 1'b1,1'b1,1'b0,8'hD1, 1'b1,1'b0,8'hD2},
    {2'd1,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'hD1, 1'b1,1'b0,8'hD2},
    {2'd2,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,8'hD2},
    {2'd2,1'b1,1'b0,8'hE1, 1'b1,1'b1,1'b0,8'hE1, 1'b1,1'b0,8'hE1},
    {2'd2,1'b1,1'b1,8'hE2, 1'b1,1'b1,1'b1,8'hE2, 1'b1,1'b1,8'hE2},
    {2'd0,1'b1,1'b0,8'hE3, 1'b1,1'b1,1'b0,8'hE3, 1'b1,1'b0,8'hE3},
    {2'd0,1'b1,1'b0,8'hE4, 1'b1,1'b1,1'b0,8'hE4, 1'b1,1'b0,8'hE4},
    {2'd0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00},
    {2'd0,1'b1,1'b0,8'hF1, 1'b1,1'b1,1'b0,8'hF1, 1'b0,1'b0,8'h00}
  };

  function automatic string row_req(input int i);
    if (i == 10 || i == 11 || i == 12) return "R6";
    if (i >= 14 && i <= 18) return "R4";
    if (i >= 4 && i <= 19) return "R3";
    if (i >= 20 && i <= 22) return "R7";
    if (i >= 23 && i <= 25) return "R8";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic f, input logic de,
                       input logic hs, input logic vs, input logic [PIX_W-1:0] p);
    @(negedge clk);
    mode_req = m; fmt_18 = f; de_in = de; hs_in = hs; vs_in = vs; pix_in = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_req = 2'd0; fmt_18 = 1'b0; pix_in = '0;
    hs_in = 1'b0; vs_in = 1'b0; de_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {link_ce, mode_act, odd_pix, odd_hs, odd_vs, odd_de, even_pix, even_hs, even_vs, even_de}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < N_ROWS; i++) begin
      logic [32:0] r;
      r = TBL[i];
      drive(r[32:31], 1'b0, r[30], r[29], 1'b0, {16'h0, r[28:21]});
      check(row_req(i),
            {link_ce, odd_de, odd_hs, odd_pix, even_de, even_hs, even_pix},
            {r[20], r[19], r[18], 16'h0, r[17:10], r[9], r[8], 16'h0, r[7:0]});
    end

    // R5: vsync rides with its own pixel in dual mode.
    drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 24'h000011);
    drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000022);
    check("R5", {link_ce, odd_vs, even_vs, odd_pix, even_pix}, {1'b1, 1'b1, 1'b0, 24'h000011, 24'h000022});
    // R10: odd slot after a load leaves the strobe low.
    drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R10", {63'h0, link_ce}, 64'h0);
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R3", {link_ce, mode_act}, {1'b1, 2'd0});

    // R9: colour depth reduction
    drive(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 24'hFFFFFF);
    check("R9", {odd_pix, even_pix}, {24'hFCFCFC, 24'h000000});
    drive(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 24'hFFFFFF);
    check("R9", {40'h0, odd_pix}, {40'h0, 24'hFFFFFF});

    // R8: reserved code behaves as single
    drive(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    drive(2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 24'h123456);
    check("R8", {mode_act, odd_pix, even_de, link_ce}, {2'd0, 24'h123456, 1'b0, 1'b1});

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {link_ce, mode_act, odd_pix, odd_hs, odd_vs, odd_de, even_pix, even_hs, even_vs, even_de}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule